// File: doc/BRIEF.md
# Dual-Rail AND with Threshold Gates

This block computes the AND of two dual-rail encoded bits under a four-phase return-to-spacer handshake. Each operand arrives on a pair of rails (true, false). The pair is all-low for the spacer, true-high for logic 1 and false-high for logic 0. The result leaves on a pair in the same code. Every output rail comes from a threshold gate with hysteresis. The gate raises its output once the weighted count of its active inputs reaches a threshold. It drops the output only after every input it watches has returned low. In every other cycle it keeps its state.

The gates are modelled as clocked state elements, so each output rail follows its inputs one clock later. A parameter selects one of two variants for the false output rail:

- **Eager variant.** The false output rail is an OR of the two false input rails. It can signal 0 as soon as one operand is 0, before the other operand has arrived.
- **Strict variant.** The false output rail comes from a 3-of-4 gate. The false rails carry weight 2 and the true rails carry weight 1. This rail can therefore only rise once both operands carry data. This completion property is what makes the output safe to use as an acknowledge.

Top module: `drand_th`

## Requirements
- R1: While `rst` is high at a rising clock edge, both `y_t` and `y_f` are 0 after that edge.
- R2: `y_t` rises at the first rising edge at which `a_t` and `b_t` are both 1. A single true input rail never raises it.
- R3: In both variants, valid operands (0,0), (0,1) and (1,0) give `y_f`=1 and `y_t`=0 one edge after they are applied. Operands (1,1) give `y_t`=1 and `y_f`=0. Rail code: (t,f)=(1,0) is logic 1, (0,1) is logic 0, (0,0) is the spacer.
- R4: With `STRICT`=1, `y_f` stays 0 while either operand is still the spacer, whatever the other operand carries.
- R5: With `STRICT`=0, `y_f` rises one edge after either false input rail rises, even while the other operand is the spacer.
- R6: Once an output rail is 1, it stays 1 while any of the four input rails is 1. It returns to 0 at the first edge at which all four input rails are 0.
- R7: With legal inputs (no operand with both rails high), `y_t` and `y_f` are never both 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock that samples the gate state elements |
| rst | input | 1 | Synchronous active-high reset, clears both output rails |
| a_t | input | 1 | Operand A, true rail |
| a_f | input | 1 | Operand A, false rail |
| b_t | input | 1 | Operand B, true rail |
| b_f | input | 1 | Operand B, false rail |
| y_t | output | 1 | Result, true rail |
| y_f | output | 1 | Result, false rail |

## Verification
Two gate functions can fall in the same cycle: holding the output and setting it. They can also collide at reset, where holding meets clearing. The bench staggers operand arrival so that one operand sits at data while the other is still the spacer. It then staggers the return so that one operand is back at the spacer while the other still holds data. Each gate must then choose between hold and set or clear in exactly the cycle in question. The outputs are sampled on the falling edge after each change, on a strict instance and an eager instance side by side. Each check is judged against the weighted-threshold and all-low-reset rules.

// File: rtl/drand_pkg.sv
package drand_pkg;

    localparam int unsigned RAIL_N = 4;     // rails watched by every gate
    localparam int unsigned WBITS  = 2;     // bits per input weight

    // rail slots inside the packed gate input vector
    localparam int unsigned SLOT_AT = 0;
    localparam int unsigned SLOT_BT = 1;
    localparam int unsigned SLOT_AF = 2;
    localparam int unsigned SLOT_BF = 3;

    typedef struct packed {
        logic tr;
        logic fa;
    } rail_pair_t;

    typedef logic [RAIL_N*WBITS-1:0] weight_vec_t;

    // weight sets, slot order {bf, af, bt, at}
    localparam weight_vec_t W_TRUE_AND  = {2'd0, 2'd0, 2'd1, 2'd1};
    localparam weight_vec_t W_FALSE_OR  = {2'd1, 2'd1, 2'd0, 2'd0};
    localparam weight_vec_t W_FALSE_SI  = {2'd2, 2'd2, 2'd1, 2'd1};

    localparam int unsigned T_TRUE_AND = 2;
    localparam int unsigned T_FALSE_OR = 1;
    localparam int unsigned T_FALSE_SI = 3;

    function automatic int unsigned weigh(input logic [RAIL_N-1:0] act,
                                          input weight_vec_t        w);
        int unsigned s;
        s = 0;
        for (int i = 0; i < RAIL_N; i++) begin
            if (act[i]) s += int'(w[i*WBITS +: WBITS]);
        end
        return s;
    endfunction

endpackage

// File: rtl/drand_thgate.sv
module drand_thgate
    import drand_pkg::*;
#(
    parameter weight_vec_t WEIGHTS = W_TRUE_AND,
    parameter int unsigned THRESH  = T_TRUE_AND
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [RAIL_N-1:0] rails,
    output logic              q
);

    logic set_now;
    logic all_low;

    always_comb begin
        set_now = (weigh(rails, WEIGHTS) >= THRESH);
        all_low = (rails == '0);
    end

    always_ff @(posedge clk) begin
        if (rst)          q <= 1'b0;
        else if (set_now) q <= 1'b1;
        else if (all_low) q <= 1'b0;
    end

    // R6: hysteresis, a set output survives while any rail is active
    a_r6_hold: assert property (@(posedge clk) disable iff (rst)
        (q && !all_low) |=> q);

    // R6: all rails low releases the output at the next edge
    a_r6_release: assert property (@(posedge clk) disable iff (rst)
        all_low |=> !q);

endmodule

// File: rtl/drand_th.sv
module drand_th
    import drand_pkg::*;
#(
    parameter bit STRICT = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic a_t,
    input  logic a_f,
    input  logic b_t,
    input  logic b_f,
    output logic y_t,
    output logic y_f
);

    localparam weight_vec_t YF_W = STRICT ? W_FALSE_SI : W_FALSE_OR;
    localparam int unsigned YF_T = STRICT ? T_FALSE_SI : T_FALSE_OR;

    rail_pair_t        op_a, op_b;
    logic [RAIL_N-1:0] rail_vec;

    always_comb begin
        op_a = '{tr: a_t, fa: a_f};
        op_b = '{tr: b_t, fa: b_f};
        rail_vec = '0;
        rail_vec[SLOT_AT] = op_a.tr;
        rail_vec[SLOT_BT] = op_b.tr;
        rail_vec[SLOT_AF] = op_a.fa;
        rail_vec[SLOT_BF] = op_b.fa;
    end

    drand_thgate #(.WEIGHTS(W_TRUE_AND), .THRESH(T_TRUE_AND)) u_true (
        .clk(clk), .rst(rst), .rails(rail_vec), .q(y_t)
    );

    drand_thgate #(.WEIGHTS(YF_W), .THRESH(YF_T)) u_false (
        .clk(clk), .rst(rst), .rails(rail_vec), .q(y_f)
    );

    // R1: synchronous reset clears both rails
    a_r1_reset_clear: assert property (@(posedge clk)
        rst |=> (!y_t && !y_f));

    // R2: both true rails raise the true output
    a_r2_true_set: assert property (@(posedge clk) disable iff (rst)
        (op_a.tr && op_b.tr) |=> y_t);

    // R2: a lone true rail never raises the true output
    a_r2_lone_true: assert property (@(posedge clk) disable iff (rst)
        (!y_t && !(op_a.tr && op_b.tr)) |=> !y_t);

    // R7: legal operands never produce both result rails
    a_r7_exclusive: assert property (@(posedge clk) disable iff (rst)
        (!(a_t && a_f) && !(b_t && b_f) && !(y_t && y_f)
         && !(y_t && (a_f || b_f)) && !(y_f && a_t && b_t)) |=> !(y_t && y_f));

    generate
        if (STRICT) begin : g_strict_chk
            // R4: no false result while operand A is the spacer
            a_r4_wait_a: assert property (@(posedge clk) disable iff (rst)
                (!op_a.tr && !op_a.fa && !y_f) |=> !y_f);
            // R4: no false result while operand B is the spacer
            a_r4_wait_b: assert property (@(posedge clk) disable iff (rst)
                (!op_b.tr && !op_b.fa && !y_f) |=> !y_f);
        end else begin : g_eager_chk
            // R5: any false rail raises the false result
            a_r5_eager: assert property (@(posedge clk) disable iff (rst)
                (op_a.fa || op_b.fa) |=> y_f);
        end
    endgenerate

endmodule

// File: tb/sim_drand_th.sv
module sim_drand_th;

    localparam time CLK_PER = 10ns;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic a_t = 0, a_f = 0, b_t = 0, b_f = 0;
    logic s_yt, s_yf, e_yt, e_yf;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    always #(CLK_PER/2) clk = ~clk;

    drand_th #(.STRICT(1'b1)) u0 (
        .clk(clk), .rst(rst), .a_t(a_t), .a_f(a_f), .b_t(b_t), .b_f(b_f),
        .y_t(s_yt), .y_f(s_yf)
    );

    drand_th #(.STRICT(1'b0)) u1 (
        .clk(clk), .rst(rst), .a_t(a_t), .a_f(a_f), .b_t(b_t), .b_f(b_f),
        .y_t(e_yt), .y_f(e_yf)
    );

    task automatic chk(input string req, input string what,
                       input logic got, input logic exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s %s: got=%b exp=%b", req, what, got, exp);
        end
    endtask

    // operand code: 2 = spacer, 1 = logic 1, 0 = logic 0
    task automatic drive(input int a, input int b);
        @(negedge clk);
        a_t = (a == 1); a_f = (a == 0);
        b_t = (b == 1); b_f = (b == 0);
    endtask

    // one edge passes, then sample on the falling edge
    task automatic settle();
        @(negedge clk);
    endtask

    task automatic t_reset();
        chk("R1", "strict y_t after reset", s_yt, 1'b0);
        chk("R1", "strict y_f after reset", s_yf, 1'b0);
        chk("R1", "eager y_f after reset",  e_yf, 1'b0);
    endtask

    task automatic t_truth();
        for (int a = 0; a < 2; a++) begin
            for (int b = 0; b < 2; b++) begin
                drive(a, b); settle();
                chk("R3", $sformatf("strict y_t %0d&%0d", a, b), s_yt, logic'(a & b));
                chk("R3", $sformatf("strict y_f %0d&%0d", a, b), s_yf, logic'(!(a & b)));
                chk("R3", $sformatf("eager y_t %0d&%0d", a, b),  e_yt, logic'(a & b));
                chk("R3", $sformatf("eager y_f %0d&%0d", a, b),  e_yf, logic'(!(a & b)));
                chk("R7", "strict rails exclusive", logic'(s_yt & s_yf), 1'b0);
                drive(2, 2); settle();
                chk("R6", "strict y_t released", s_yt, 1'b0);
                chk("R6", "strict y_f released", s_yf, 1'b0);
                chk("R6", "eager y_f released",  e_yf, 1'b0);
            end
        end
    endtask

    task automatic t_early_false();
        drive(0, 2); settle(); settle();
        chk("R4", "strict y_f with B spacer", s_yf, 1'b0);
        chk("R5", "eager y_f with B spacer",  e_yf, 1'b1);
        drive(2, 2); settle();
        drive(2, 0); settle(); settle();
        chk("R4", "strict y_f with A spacer", s_yf, 1'b0);
        drive(1, 0); settle();
        chk("R3", "strict y_f once A arrives", s_yf, 1'b1);
        drive(2, 0); settle();
        chk("R6", "strict y_f held, B still data", s_yf, 1'b1);
        chk("R6", "eager y_f held, B still data",  e_yf, 1'b1);
        drive(2, 2); settle();
        chk("R6", "strict y_f cleared", s_yf, 1'b0);
        chk("R6", "eager y_f cleared",  e_yf, 1'b0);
    endtask

    task automatic t_true_path();
        drive(1, 2); settle();
        chk("R2", "strict y_t with lone a_t", s_yt, 1'b0);
        chk("R2", "eager y_t with lone a_t",  e_yt, 1'b0);
        chk("R4", "strict y_f with lone a_t", s_yf, 1'b0);
        drive(1, 1); settle();
        chk("R2", "strict y_t both true", s_yt, 1'b1);
        drive(2, 1); settle();
        chk("R6", "strict y_t held on b_t", s_yt, 1'b1);
        chk("R6", "eager y_t held on b_t",  e_yt, 1'b1);
        drive(2, 2); settle();
        chk("R6", "strict y_t cleared", s_yt, 1'b0);
    endtask

    task automatic t_mid_reset();
        drive(0, 1); settle();
        chk("R3", "strict y_f before reset", s_yf, 1'b1);
        @(negedge clk); rst = 1'b1;
        settle();
        chk("R1", "strict y_f cleared by reset", s_yf, 1'b0);
        chk("R1", "eager y_f cleared by reset",  e_yf, 1'b0);
        @(negedge clk); rst = 1'b0;
        drive(2, 2); settle();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst = 1'b0;
        settle();
        t_truth();
        t_early_false();
        t_true_path();
        t_mid_reset();
        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (2000) @(posedge clk);
                n_chk++;
                n_bad++;
                $display("FAIL watchdog: got=timeout exp=done");
            end
        join_any
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule